// File: doc/BRIEF.md
# Event-Gated Counter Register Access Arbiter

This block sits between the byte-level front end of a serial slave interface and the storage that holds two counters. The first is a 32-bit elapsed-time count and the second is a 16-bit event count. Each counter exists twice: as a working copy that the counter logic advances, and as a non-volatile mirror. The arbiter decides, from the level of an already-filtered event input, whether each host byte read or write is served. It also decides which copy a read returns, and when a host write may update both copies.

The event input governs access in three ways. While it is high, the counter logic owns the working copy: host writes are refused, but reads continue and return a snapshot taken at the bus start. When it falls, the mirror is being programmed, so all host access is refused for a fixed number of clock cycles. After that the mirror serves reads and host writes are accepted. Written bytes wait in a holding buffer. They are merged with the current mirror contents and issued as update strobes only when the bus stop arrives. If the event input rises while such bytes are waiting, the write is aborted.

Top module: `evt_access_arb`

## Requirements
- R1: While `evt_level` is high, every write byte is refused (`wr_rej`), and every read byte is still served (`rd_valid`).
- R2: A fall of `evt_level` opens a lockout of `LOCK_CYC` cycles. A request sampled on the falling edge's clock or on any of the next `LOCK_CYC-1` clocks is refused, whether it is a read (`rd_rej`) or a write (`wr_rej`), and `lock_busy` is high for that whole window. From the following clock on, requests are served again.
- R3: If `evt_level` rises while accepted bytes are staged, `wr_abort` pulses for one cycle on the next clock and the staged bytes are discarded. The following bus stop then produces no update strobe.
- R4: The read source is fixed at each bus start. A rise of `evt_level` later in the same transaction does not change the source, and the read still completes.
- R5: A bus start sampled with `evt_level` high captures `work_etc` and `work_evt` into a snapshot. Reads in that transaction return the snapshot, even if the working values change afterwards.
- R6: A bus start sampled with `evt_level` low makes reads in that transaction return the current `mirror_etc` and `mirror_evt`.
- R7: Byte addresses are little-endian. Addresses 0 to 3 hold elapsed-time bits [7:0], [15:8], [23:16] and [31:24]. Addresses 4 and 5 hold event-count bits [7:0] and [15:8]. The cycle after a bus stop in a transaction with staged bytes, `upd_etc_stb` and/or `upd_evt_stb` pulse for each register that has a staged byte. `upd_etc` and `upd_evt` then carry the mirror contents with the staged bytes substituted. No strobe is issued before the stop.
- R8: A refused write byte or an abort sets the sticky `wr_err` flag, and a completed update clears it. After a refused byte, the remaining write bytes of the same transaction are refused as well.
- R9: A write to address 6 or 7 is refused, and a read from address 6 or 7 returns 0x00.
- R10: A write byte is refused while `mirror_busy` is high, and also when no transaction is open (no bus start since the last bus stop).
- R11: Every write byte gets exactly one of `wr_ack` or `wr_rej`, and every read byte exactly one of `rd_valid` or `rd_rej`, one cycle after the request. After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_start | input | 1 | One-cycle pulse: bus start detected |
| bus_stop | input | 1 | One-cycle pulse: bus stop detected |
| wr_req | input | 1 | Write byte request |
| wr_addr | input | AW (3) | Write byte address |
| wr_data | input | 8 | Write byte value |
| rd_req | input | 1 | Read byte request |
| rd_addr | input | AW (3) | Read byte address |
| evt_level | input | 1 | Filtered event level |
| mirror_busy | input | 1 | Mirror programming in progress |
| work_etc | input | 32 | Working elapsed-time count |
| work_evt | input | 16 | Working event count |
| mirror_etc | input | 32 | Mirror elapsed-time count |
| mirror_evt | input | 16 | Mirror event count |
| rd_data | output | 8 | Read byte value |
| rd_valid | output | 1 | Read served |
| rd_rej | output | 1 | Read refused |
| wr_ack | output | 1 | Write byte accepted |
| wr_rej | output | 1 | Write byte refused |
| wr_abort | output | 1 | Staged write aborted by event rise |
| wr_err | output | 1 | Sticky write error flag |
| lock_busy | output | 1 | Post-fall lockout running |
| upd_etc_stb | output | 1 | Load strobe for both elapsed-time copies |
| upd_evt_stb | output | 1 | Load strobe for both event-count copies |
| upd_etc | output | 32 | Elapsed-time value to load |
| upd_evt | output | 16 | Event-count value to load |

## Verification
The bench builds the arbiter with `LOCK_CYC` set to 8 and the default 4-byte and 2-byte counters. This makes it cheap to sweep a write and a read through every request offset from the falling edge up to two cycles past the end of the lockout, so both window edges are hit exactly. With only six mapped byte addresses, the bench reads all eight addresses in both the mirror and the snapshot source. It also commits every single-byte write and a full six-byte write, with the merged values computed by shifting and masking in the bench. Separate sequences cover an abort, a rise partway through a read transaction, a poisoned transaction, and refusals on a busy mirror or with no open transaction.

// File: rtl/evt_access_arb.sv
module evt_access_arb #(
  parameter int unsigned LOCK_CYC  = 1000,
  parameter int unsigned ETC_BYTES = 4,
  parameter int unsigned EVC_BYTES = 2,
  localparam int unsigned NB    = ETC_BYTES + EVC_BYTES,
  localparam int unsigned AW    = $clog2(NB + 1),
  localparam int unsigned ETC_W = 8 * ETC_BYTES,
  localparam int unsigned EVC_W = 8 * EVC_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic             wr_req,
  input  logic [AW-1:0]    wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             rd_req,
  input  logic [AW-1:0]    rd_addr,
  input  logic             evt_level,
  input  logic             mirror_busy,
  input  logic [ETC_W-1:0] work_etc,
  input  logic [EVC_W-1:0] work_evt,
  input  logic [ETC_W-1:0] mirror_etc,
  input  logic [EVC_W-1:0] mirror_evt,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             rd_rej,
  output logic             wr_ack,
  output logic             wr_rej,
  output logic             wr_abort,
  output logic             wr_err,
  output logic             lock_busy,
  output logic             upd_etc_stb,
  output logic             upd_evt_stb,
  output logic [ETC_W-1:0] upd_etc,
  output logic [EVC_W-1:0] upd_evt
);
  localparam int unsigned TW = 8 * NB;
  localparam int unsigned CW = $clog2(LOCK_CYC + 1);

  logic          evt_q;
  logic [CW-1:0] lock_cnt;
  logic          txn_open, txn_bad, src_snap;
  logic [TW-1:0] snap_all, stg_all, merged;
  logic [NB-1:0] mask;
  logic [7:0]    rd_byte;

  wire [TW-1:0] mir_all  = {mirror_evt, mirror_etc};
  wire [TW-1:0] work_all = {work_evt, work_etc};
  wire [TW-1:0] src_all  = src_snap ? snap_all : mir_all;

  wire evt_rise = evt_level & ~evt_q;
  wire evt_fall = ~evt_level & evt_q;
  assign lock_busy = ~evt_level & (evt_fall | (lock_cnt != '0));

  wire wr_in_rng  = int'(wr_addr) < int'(NB);
  wire wr_ok      = wr_req & txn_open & ~txn_bad & ~evt_level & ~lock_busy & ~mirror_busy & wr_in_rng;
  wire wr_bad     = wr_req & ~wr_ok;
  wire staged     = mask != '0;
  wire abort_now  = evt_rise & staged;
  wire commit_now = bus_stop & staged & ~txn_bad & ~evt_rise;
  wire rd_ok      = rd_req & ~lock_busy;

  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign merged[8*b +: 8] = mask[b] ? stg_all[8*b +: 8] : mir_all[8*b +: 8];
  end

  always_comb begin
    rd_byte = '0;
    for (int b = 0; b < NB; b++)
      if (rd_addr == AW'(b)) rd_byte = src_all[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q    <= 1'b0;
      lock_cnt <= '0;
    end else begin
      evt_q <= evt_level;
      if (evt_rise)                 lock_cnt <= '0;
      else if (evt_fall)            lock_cnt <= CW'(LOCK_CYC - 1);
      else if (lock_cnt != '0)      lock_cnt <= lock_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txn_open <= 1'b0;
      txn_bad  <= 1'b0;
      src_snap <= 1'b0;
      snap_all <= '0;
      stg_all  <= '0;
      mask     <= '0;
      wr_err   <= 1'b0;
    end else begin
      if (bus_start) begin
        txn_open <= 1'b1;
        txn_bad  <= 1'b0;
        src_snap <= evt_level;
        if (evt_level) snap_all <= work_all;
      end else if (bus_stop) begin
        txn_open <= 1'b0;
      end
      if (abort_now | wr_bad) txn_bad <= 1'b1;

      if (abort_now | wr_bad | bus_start | bus_stop) begin
        mask <= '0;
      end else begin
        for (int b = 0; b < NB; b++)
          if (wr_ok && wr_addr == AW'(b)) begin
            mask[b]          <= 1'b1;
            stg_all[8*b +: 8] <= wr_data;
          end
      end

      if (abort_now | wr_bad) wr_err <= 1'b1;
      else if (commit_now)    wr_err <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ack      <= 1'b0;
      wr_rej      <= 1'b0;
      wr_abort    <= 1'b0;
      rd_valid    <= 1'b0;
      rd_rej      <= 1'b0;
      rd_data     <= '0;
      upd_etc_stb <= 1'b0;
      upd_evt_stb <= 1'b0;
      upd_etc     <= '0;
      upd_evt     <= '0;
    end else begin
      wr_ack      <= wr_ok;
      wr_rej      <= wr_bad;
      wr_abort    <= abort_now;
      rd_valid    <= rd_ok;
      rd_rej      <= rd_req & ~rd_ok;
      if (rd_ok) rd_data <= rd_byte;
      upd_etc_stb <= commit_now & (mask[ETC_BYTES-1:0] != '0);
      upd_evt_stb <= commit_now & (mask[NB-1:ETC_BYTES] != '0);
      if (commit_now) begin
        upd_etc <= merged[ETC_W-1:0];
        upd_evt <= merged[TW-1:ETC_W];
      end
    end
  end
endmodule

module evt_access_arb_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_req,
  input logic rd_req,
  input logic evt_level,
  input logic lock_busy,
  input logic wr_ack,
  input logic wr_rej,
  input logic rd_valid,
  input logic rd_rej,
  input logic wr_abort,
  input logic upd_etc_stb,
  input logic upd_evt_stb
);
  AST_WR_BLOCK_HIGH:   assert property (@(posedge clk) disable iff (!rst_n) wr_req && evt_level |=> wr_rej && !wr_ack); // R1
  AST_RD_SERVED_HIGH:  assert property (@(posedge clk) disable iff (!rst_n) rd_req && evt_level |=> rd_valid); // R1
  AST_LOCK_RD_REFUSED: assert property (@(posedge clk) disable iff (!rst_n) rd_req && lock_busy |=> rd_rej && !rd_valid); // R2
  AST_LOCK_WR_REFUSED: assert property (@(posedge clk) disable iff (!rst_n) wr_req && lock_busy |=> wr_rej); // R2
  AST_ABORT_ON_RISE:   assert property (@(posedge clk) disable iff (!rst_n) wr_abort |-> $past(evt_level)); // R3
  AST_ABORT_NO_UPD:    assert property (@(posedge clk) disable iff (!rst_n) wr_abort |-> !upd_etc_stb && !upd_evt_stb); // R3
  AST_UPD_WHILE_LOW:   assert property (@(posedge clk) disable iff (!rst_n) (upd_etc_stb || upd_evt_stb) |-> !$past(evt_level)); // R7
  AST_WR_ONE_REPLY:    assert property (@(posedge clk) disable iff (!rst_n) wr_req |=> $countones({wr_ack, wr_rej}) == 1); // R11
  AST_RD_ONE_REPLY:    assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> $countones({rd_valid, rd_rej}) == 1); // R11
endmodule

bind evt_access_arb evt_access_arb_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req), .evt_level(evt_level),
  .lock_busy(lock_busy), .wr_ack(wr_ack), .wr_rej(wr_rej), .rd_valid(rd_valid),
  .rd_rej(rd_rej), .wr_abort(wr_abort), .upd_etc_stb(upd_etc_stb), .upd_evt_stb(upd_evt_stb)
);

// File: tb/evt_access_arb_tb.sv
module evt_access_arb_tb_top;
  localparam int L = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, bus_start, bus_stop, wr_req, rd_req, evt_level, mirror_busy;
  logic [2:0]  wr_addr, rd_addr;
  logic [7:0]  wr_data, rd_data;
  logic [31:0] wk_etc, mir_etc, upd_etc;
  logic [15:0] wk_evt, mir_evt, upd_evt;
  logic        rd_valid, rd_rej, wr_ack, wr_rej, wr_abort, wr_err, lock_busy, upd_etc_stb, upd_evt_stb;

  evt_access_arb #(.LOCK_CYC(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .evt_level(evt_level), .mirror_busy(mirror_busy),
    .work_etc(wk_etc), .work_evt(wk_evt), .mirror_etc(mir_etc), .mirror_evt(mir_evt),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_rej(rd_rej), .wr_ack(wr_ack), .wr_rej(wr_rej),
    .wr_abort(wr_abort), .wr_err(wr_err), .lock_busy(lock_busy),
    .upd_etc_stb(upd_etc_stb), .upd_evt_stb(upd_evt_stb), .upd_etc(upd_etc), .upd_evt(upd_evt)
  );

  int total = 0, bad = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pick(input logic [47:0] v, input int a);
    return (a < 6) ? v[8*a +: 8] : 8'h00;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pstart();
    bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
  endtask

  task automatic pstop();
    bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
  endtask

  task automatic dowr(input int a, input logic [7:0] d, output logic ack, output logic rej);
    wr_req = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_req = 1'b0;
    ack = wr_ack; rej = wr_rej;
  endtask

  task automatic dord(input int a, output logic v, output logic r, output logic [7:0] d);
    rd_req = 1'b1; rd_addr = 3'(a);
    @(negedge clk);
    rd_req = 1'b0;
    v = rd_valid; r = rd_rej; d = rd_data;
  endtask

  task automatic apply_upd();
    if (upd_etc_stb) mir_etc = upd_etc;
    if (upd_evt_stb) mir_evt = upd_evt;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack, rej, v, r;
    logic [7:0] d;
    logic [47:0] exp_all;
    rst_n = 1'b0; bus_start = 0; bus_stop = 0; wr_req = 0; rd_req = 0;
    wr_addr = 0; rd_addr = 0; wr_data = 0; evt_level = 0; mirror_busy = 0;
    wk_etc = 32'h0; wk_evt = 16'h0; mir_etc = 32'h89AB_CDEF; mir_evt = 16'h1357;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R11 reset state
    chk("R11 reset outputs", {wr_ack, wr_rej, rd_valid, rd_rej, wr_abort, upd_etc_stb, upd_evt_stb}, 7'b0);
    chk("R8 reset wr_err", wr_err, 1'b0);
    chk("R2 reset lock_busy", lock_busy, 1'b0);

    // R6 and R9: mirror source, all addresses
    pstart();
    for (int a = 0; a < 8; a++) begin
      dord(a, v, r, d);
      chk(a < 6 ? "R6 mirror read valid" : "R9 high addr read valid", {v, r}, 2'b10);
      chk(a < 6 ? "R6 mirror read data" : "R9 high addr read zero", d, pick({mir_evt, mir_etc}, a));
    end
    mir_etc = 32'h0246_8ACE;
    dord(0, v, r, d);
    chk("R6 mirror read follows live mirror", d, 8'hCE);
    pstop();

    // R5 and R1: snapshot at start while high, writes refused
    evt_level = 1'b1; cyc(2);
    wk_etc = 32'hA1B2_C3D4; wk_evt = 16'hE5F6;
    pstart();
    wk_etc = 32'h1111_2222; wk_evt = 16'h3333;
    for (int a = 0; a < 8; a++) begin
      dord(a, v, r, d);
      chk("R1 read served while high", {v, r}, 2'b10);
      chk(a < 6 ? "R5 snapshot data" : "R9 high addr read zero", d, pick({16'hE5F6, 32'hA1B2_C3D4}, a));
    end
    dowr(0, 8'h55, ack, rej);
    chk("R1 write refused while high", {ack, rej}, 2'b01);
    chk("R8 error set by refusal", wr_err, 1'b1);
    pstop();
    chk("R7 no update after refused txn", {upd_etc_stb, upd_evt_stb}, 2'b00);

    // R2: lockout sweep, writes then reads
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k <= L + 1; k++) begin
        evt_level = 1'b1; cyc(2);
        pstart();
        evt_level = 1'b0;
        #1;
        cyc(k);
        if (k > 0) #1;
        chk("R2 lock_busy window", lock_busy, (k < L));
        if (m == 0) begin
          dowr(k % 6, 8'(8'h20 + k), ack, rej);
          chk("R2 write reply vs lockout", {ack, rej}, (k >= L) ? 2'b10 : 2'b01);
          exp_all = {mir_evt, mir_etc};
          exp_all[8*(k%6) +: 8] = 8'(8'h20 + k);
          pstop();
          if (k >= L) begin
            chk("R7 commit after lockout etc", {upd_etc_stb, upd_etc}, {(k % 6) < 4, exp_all[31:0]});
            chk("R8 error cleared by commit", wr_err, 1'b0);
            apply_upd();
          end else begin
            chk("R8 error kept after refusal", wr_err, 1'b1);
            chk("R7 no update in lockout", {upd_etc_stb, upd_evt_stb}, 2'b00);
          end
        end else begin
          dord(1, v, r, d);
          chk("R2 read reply vs lockout", {v, r}, (k >= L) ? 2'b10 : 2'b01);
          pstop();
        end
      end
    end
    cyc(L + 2);

    // R7: every single byte, then all bytes
    for (int a = 0; a < 6; a++) begin
      pstart();
      dowr(a, 8'(8'h10 + 17 * a), ack, rej);
      chk("R7 write accepted", {ack, rej}, 2'b10);
      cyc(2);
      chk("R7 no update before stop", {upd_etc_stb, upd_evt_stb}, 2'b00);
      exp_all = {mir_evt, mir_etc};
      exp_all[8*a +: 8] = 8'(8'h10 + 17 * a);
      pstop();
      chk("R7 strobe select", {upd_etc_stb, upd_evt_stb}, (a < 4) ? 2'b10 : 2'b01);
      if (a < 4) chk("R7 merged etc", upd_etc, exp_all[31:0]);
      else       chk("R7 merged evt", upd_evt, exp_all[47:32]);
      apply_upd();
      cyc(1);
    end
    pstart();
    for (int a = 0; a < 6; a++) dowr(a, 8'(8'hC0 + a), ack, rej);
    pstop();
    chk("R7 full write strobes", {upd_etc_stb, upd_evt_stb}, 2'b11);
    chk("R7 full write etc", upd_etc, 32'hC3C2_C1C0);
    chk("R7 full write evt", upd_evt, 16'hC5C4);
    apply_upd();
    cyc(1);

    // R10: busy mirror, no open transaction; R9 high addresses
    mirror_busy = 1'b1;
    pstart();
    dowr(2, 8'h77, ack, rej);
    chk("R10 refused while mirror busy", {ack, rej}, 2'b01);
    pstop();
    mirror_busy = 1'b0;
    dowr(2, 8'h77, ack, rej);
    chk("R10 refused outside transaction", {ack, rej}, 2'b01);
    for (int a = 6; a < 8; a++) begin
      pstart();
      dowr(a, 8'h99, ack, rej);
      chk("R9 high addr write refused", {ack, rej}, 2'b01);
      pstop();
    end

    // R8: poisoned transaction
    pstart();
    dowr(7, 8'h01, ack, rej);
    dowr(0, 8'h02, ack, rej);
    chk("R8 later byte refused after refusal", {ack, rej}, 2'b01);
    pstop();
    chk("R8 no update from poisoned txn", {upd_etc_stb, upd_evt_stb}, 2'b00);
    chk("R8 error sticky", wr_err, 1'b1);

    // R3: abort on rise with staged bytes
    pstart();
    dowr(0, 8'hAA, ack, rej);
    chk("R3 byte accepted before rise", {ack, rej}, 2'b10);
    evt_level = 1'b1;
    @(negedge clk);
    chk("R3 abort pulse", wr_abort, 1'b1);
    chk("R3 error set by abort", wr_err, 1'b1);
    @(negedge clk);
    chk("R3 abort is one cycle", wr_abort, 1'b0);
    pstop();
    chk("R3 no update after abort", {upd_etc_stb, upd_evt_stb}, 2'b00);
    evt_level = 1'b0; cyc(L + 2);

    // R4: source kept across a rise within the transaction
    pstart();
    dord(1, v, r, d);
    chk("R4 mirror read before rise", d, mir_etc[15:8]);
    wk_etc = 32'h5A5A_5A5A;
    evt_level = 1'b1;
    cyc(1);
    dord(1, v, r, d);
    chk("R4 read completes after rise", {v, r}, 2'b10);
    chk("R4 source unchanged after rise", d, mir_etc[15:8]);
    pstop();
    pstart();
    dord(1, v, r, d);
    chk("R5 new start while high uses snapshot", d, 8'h5A);
    pstop();
    evt_level = 1'b0; cyc(L + 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule